// File: doc/BRIEF.md
# Dual Event Counter with Privilege Filtering

This block gives a processor core two 32-bit event counters for profiling. Each counter watches one of sixteen event inputs, chosen by its own four-bit selector in a shared control word. It adds one per clock while that event is high and the core's current privilege mode is among the modes the control word allows. Software arms a sample period by preloading a counter with 0x80000000 minus the period. When bit 31 of either counter becomes set and the interrupt enable is on, a level interrupt is raised. It stays raised until software rewrites the counters.

Register access uses one 64-bit port with a single select bit. Select 0 addresses the control word. Select 1 addresses both counters packed into one 64-bit word, and one write loads both halves together. Reads are combinational from the held registers. Writing zero to the control word stops all counting.

Top module: `dual_evtcnt`

## Requirements
- R1: After reset the control word and both counters read as zero and `irq` is low.
- R2: A write with `reg_sel`=0 stores `reg_wdata[12:0]` as the control word. The fields are: mode enables in [3:0], interrupt enable in [4], counter A event select in [8:5], counter B event select in [12:9]. A read with `reg_sel`=0 returns the stored value zero-extended to 64 bits.
- R3: A write with `reg_sel`=1 loads counter A from `reg_wdata[31:0]` and counter B from `reg_wdata[63:32]`. A read with `reg_sel`=1 returns {B, A} in the same layout.
- R4: Counter A adds one at a clock edge when `evt_in[ctl[8:5]]` is high and the mode is enabled. Counter B does the same with `evt_in[ctl[12:9]]`.
- R5: `priv_mode` encodes 0 as exception level, 1 as kernel, 2 as supervisor and 3 as user, qualified by control bits 0, 1, 2 and 3 respectively. While the bit for the current mode is clear, neither counter changes.
- R6: With the control word zero, neither counter changes whatever the events and modes.
- R7: Counting continues past bit 31 and wraps from 0xFFFFFFFF to 0.
- R8: A counter write in the same cycle as a qualifying event loads the written value, and that cycle's increment is lost.
- R9: `irq` is high exactly when (A[31] or B[31]) and control bit 4 are both set.
- R10: `irq` falls after software writes counter values whose bit 31 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control word, 1 = packed counters |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register |
| evt_in | input | 16 | Event inputs, one per selectable event |
| priv_mode | input | 2 | Current privilege mode |
| irq | output | 1 | Level overflow interrupt |

## Verification
Every stored value, whether it comes from a write or a count, takes effect at the first rising edge after the cycle that drives it. `reg_rdata` and `irq` are combinational from those registers, so each result is visible in the cycle after its stimulus. The bench drives inputs at the falling edge and samples one nanosecond later, before the next rising edge. Its model applies each cycle's events and writes only when that rising edge passes. Random traffic mixes writes, events and modes, and directed cases cover the flag crossing, wraparound, write priority and the stopped state.

// File: rtl/dual_evtcnt_pkg.sv
package dual_evtcnt_pkg;

  localparam int CTR_W    = 32;
  localparam int NUM_CTR  = 2;
  localparam int SEL_W    = 4;
  localparam int NUM_EVT  = 1 << SEL_W;
  localparam int MODE_W   = 2;
  localparam int NUM_MODE = 1 << MODE_W;
  localparam int CTL_W    = NUM_MODE + 1 + NUM_CTR * SEL_W;
  localparam int DATA_W   = NUM_CTR * CTR_W;
  localparam int FLAG_BIT = CTR_W - 1;
  localparam int IEN_BIT  = NUM_MODE;

  typedef enum logic [MODE_W-1:0] {
    PRIV_EXC  = 2'd0,
    PRIV_KERN = 2'd1,
    PRIV_SUPV = 2'd2,
    PRIV_USER = 2'd3
  } priv_e;

  // Layout from MSB: counter selects (highest counter first), irq enable, mode enables.
  typedef struct packed {
    logic [NUM_CTR-1:0][SEL_W-1:0] sel;
    logic                          irq_en;
    logic [NUM_MODE-1:0]           mode_en;
  } ctl_t;

  function automatic logic mode_gate(input logic [NUM_MODE-1:0] en,
                                     input logic [MODE_W-1:0]   mode);
    return en[mode];
  endfunction

  function automatic logic [CTR_W-1:0] count_next(input logic [CTR_W-1:0] cur,
                                                  input logic             ld,
                                                  input logic [CTR_W-1:0] ld_val,
                                                  input logic             inc);
    logic [CTR_W-1:0] nxt;
    nxt = cur;
    if (inc) nxt = cur + {{(CTR_W-1){1'b0}}, 1'b1};
    if (ld)  nxt = ld_val;
    return nxt;
  endfunction

  function automatic logic flag_of(input logic [CTR_W-1:0] cnt);
    return cnt[FLAG_BIT];
  endfunction

endpackage

// File: rtl/dual_evtcnt_ctrl.sv
module dual_evtcnt_ctrl
  import dual_evtcnt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_ctl,
  input  logic [CTL_W-1:0]  ld_val,
  input  logic [MODE_W-1:0] priv_mode,
  output ctl_t              ctl_q,
  output logic              mode_ok
);

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ld_ctl) ctl_q <= ctl_t'(ld_val);
  end

  assign mode_ok = mode_gate(ctl_q.mode_en, priv_mode);

endmodule

// File: rtl/dual_evtcnt_lane.sv
module dual_evtcnt_lane
  import dual_evtcnt_pkg::*;
#(
  parameter int LANE_W = CTR_W,
  parameter int LANE_SEL_W = SEL_W,
  localparam int LANE_EVT = 1 << LANE_SEL_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANE_EVT-1:0]   evt,
  input  logic [LANE_SEL_W-1:0] sel,
  input  logic                  mode_ok,
  input  logic                  ld,
  input  logic [LANE_W-1:0]     ld_val,
  output logic [LANE_W-1:0]     cnt_q,
  output logic                  inc
);

  logic evt_hit;

  assign evt_hit = evt[sel];
  assign inc     = evt_hit & mode_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= count_next(cnt_q, ld, ld_val, inc);
  end

endmodule

// File: rtl/dual_evtcnt.sv
module dual_evtcnt
  import dual_evtcnt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [MODE_W-1:0] priv_mode,
  output logic              irq
);

  ctl_t                          ctl_q;
  logic                          mode_ok;
  logic                          ld_ctl;
  logic                          ld_cnt;
  logic [NUM_CTR-1:0][CTR_W-1:0] cnt_q;
  logic [NUM_CTR-1:0]            cnt_inc;
  logic [NUM_CTR-1:0]            cnt_flag;
  logic                          any_flag;

  assign ld_ctl = reg_wr & ~reg_sel;
  assign ld_cnt = reg_wr &  reg_sel;

  dual_evtcnt_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_ctl    (ld_ctl),
    .ld_val    (reg_wdata[CTL_W-1:0]),
    .priv_mode (priv_mode),
    .ctl_q     (ctl_q),
    .mode_ok   (mode_ok)
  );

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_lane
    dual_evtcnt_lane #(
      .LANE_W     (CTR_W),
      .LANE_SEL_W (SEL_W)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt_in),
      .sel     (ctl_q.sel[k]),
      .mode_ok (mode_ok),
      .ld      (ld_cnt),
      .ld_val  (reg_wdata[k*CTR_W +: CTR_W]),
      .cnt_q   (cnt_q[k]),
      .inc     (cnt_inc[k])
    );
    assign cnt_flag[k] = flag_of(cnt_q[k]);
  end

  assign any_flag  = |cnt_flag;
  assign irq       = any_flag & ctl_q.irq_en;
  assign reg_rdata = reg_sel ? cnt_q : {{(DATA_W-CTL_W){1'b0}}, ctl_q};

endmodule

// File: rtl/dual_evtcnt_chk.sv
module dual_evtcnt_chk
  import dual_evtcnt_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_wr,
  input logic                          reg_sel,
  input logic [DATA_W-1:0]             reg_wdata,
  input logic                          irq,
  input logic [CTL_W-1:0]              ctl_q,
  input logic [NUM_CTR-1:0][CTR_W-1:0] cnt_q,
  input logic [NUM_CTR-1:0]            cnt_inc
);

  logic ld_cnt;
  assign ld_cnt = reg_wr & reg_sel;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cnt |=> (cnt_q == $past(reg_wdata))); // R8

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_chk
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_cnt && cnt_inc[k]) |=>
        (cnt_q[k] == $past(cnt_q[k]) + {{(CTR_W-1){1'b0}}, 1'b1})); // R4
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_cnt && !cnt_inc[k]) |=> $stable(cnt_q[k])); // R5
  end

  AST_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[NUM_MODE-1:0] == '0 && !ld_cnt) |=> $stable(cnt_q)); // R6

  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctl_q[IEN_BIT]); // R9

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt_q[0][FLAG_BIT] | cnt_q[NUM_CTR-1][FLAG_BIT])); // R10

endmodule

bind dual_evtcnt dual_evtcnt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .irq       (irq),
  .ctl_q     (ctl_q),
  .cnt_q     (cnt_q),
  .cnt_inc   (cnt_inc)
);

// File: tb/tb_dual_evtcnt.sv
module tb_dual_evtcnt;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [15:0] evt_in = '0;
  logic [1:0]  priv_mode = '0;
  logic        irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic [12:0] m_ctl = '0;
  logic [31:0] m_a = '0;
  logic [31:0] m_b = '0;

  always #10 clk = ~clk;

  dual_evtcnt dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .priv_mode(priv_mode), .irq(irq)
  );

  function automatic logic [12:0] mk_ctl(input logic [3:0] sb, input logic [3:0] sa,
                                         input logic ie, input logic [3:0] men);
    return {sb, sa, ie, men};
  endfunction

  function automatic logic allowed(input logic [12:0] c, input logic [1:0] md);
    case (md)
      2'd0:    return c[0];
      2'd1:    return c[1];
      2'd2:    return c[2];
      default: return c[3];
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic sel, input logic [63:0] wd,
                      input logic [15:0] ev, input logic [1:0] md, input string tag);
    logic [31:0] na, nb;
    logic [12:0] nc;
    logic        ok;
    @(negedge clk);
    reg_wr = wr; reg_sel = sel; reg_wdata = wd; evt_in = ev; priv_mode = md;
    #1;
    chk({tag, " irq"}, {63'd0, irq}, {63'd0, (m_a[31] | m_b[31]) & m_ctl[4]});
    if (!wr) chk({tag, " rdata"}, reg_rdata, sel ? {m_b, m_a} : {51'd0, m_ctl});
    ok = allowed(m_ctl, md);
    na = (ok && ev[m_ctl[8:5]])  ? m_a + 32'd1 : m_a;
    nb = (ok && ev[m_ctl[12:9]]) ? m_b + 32'd1 : m_b;
    if (wr && sel) begin na = wd[31:0]; nb = wd[63:32]; end
    nc = (wr && !sel) ? wd[12:0] : m_ctl;
    @(posedge clk);
    m_a = na; m_b = nb; m_ctl = nc;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    step(0, 0, '0, '0, 0, "R1 ctl");
    step(0, 1, '0, '0, 0, "R1 cnt");

    // R2: control write, upper bits discarded
    step(1, 0, 64'hDEAD_BEEF_0000_FFFF, '0, 0, "R2 wr");
    step(0, 0, '0, '0, 0, "R2 read");
    step(1, 0, 64'h0, '0, 0, "R2 clr");

    // R3: packed counter write and read
    step(1, 1, 64'h1234_5678_0000_0010, '0, 0, "R3 wr");
    step(0, 1, '0, '0, 0, "R3 read");

    // R5: kernel only, selects A=3 B=7; count in kernel, not in user
    step(1, 0, {51'd0, mk_ctl(4'd7, 4'd3, 1'b0, 4'b0010)}, '0, 0, "R5 cfg");
    step(0, 1, '0, 16'h0088, 2'd1, "R4 R5 kern");
    step(0, 1, '0, 16'h0088, 2'd3, "R5 user");
    step(0, 1, '0, 16'h0008, 2'd0, "R5 exc");
    step(0, 1, '0, 16'h0080, 2'd1, "R4 B only");
    step(0, 1, '0, '0, 2'd1, "R4 readback");

    // R9: flag crossing raises irq
    step(1, 0, {51'd0, mk_ctl(4'd2, 4'd1, 1'b1, 4'b1111)}, '0, 0, "R9 cfg");
    step(1, 1, {32'd5, 32'h7FFF_FFFE}, '0, 0, "R9 preload");
    step(0, 1, '0, 16'h0002, 2'd0, "R9 ev1");
    step(0, 1, '0, 16'h0002, 2'd2, "R9 ev2");
    step(0, 1, '0, '0, 2'd2, "R9 raised");
    step(1, 0, {51'd0, mk_ctl(4'd2, 4'd1, 1'b0, 4'b1111)}, '0, 0, "R9 mask");
    step(0, 1, '0, '0, 0, "R9 masked");
    step(1, 0, {51'd0, mk_ctl(4'd2, 4'd1, 1'b1, 4'b1111)}, '0, 0, "R9 unmask");
    step(0, 1, '0, '0, 0, "R9 again");
    // R10: rewrite clears
    step(1, 1, {32'd0, 32'h0000_0100}, '0, 0, "R10 clear");
    step(0, 1, '0, '0, 0, "R10 low");

    // R7: wraparound
    step(1, 1, {32'hFFFF_FFFF, 32'hFFFF_FFFF}, '0, 0, "R7 preload");
    step(0, 1, '0, 16'h0006, 2'd3, "R7 wrap");
    step(0, 1, '0, '0, 2'd3, "R7 zero");

    // R8: write beats increment
    step(1, 1, {32'hAAAA_0000, 32'h5555_0000}, 16'hFFFF, 2'd3, "R8 wr");
    step(0, 1, '0, '0, 2'd3, "R8 loaded");

    // R6: zero control stops counting
    step(1, 0, '0, '0, 0, "R6 stop");
    for (int i = 0; i < 4; i++) step(0, 1, '0, 16'hFFFF, i[1:0], "R6 hold");

    // Random traffic: R4 R5 R8 R9
    for (int i = 0; i < 400; i++) begin
      logic w, s;
      w = ($urandom % 8) == 0;
      s = $urandom % 2;
      step(w, s, {$urandom, $urandom}, 16'($urandom), 2'($urandom), "R4 R5 R8 R9 rand");
    end
    step(0, 1, '0, '0, 0, "R4 final");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule